// File: doc/BRIEF.md
# Serial Diagnostic Word Readout

This block collects the status of a four-channel power switch (per-channel load faults, the commanded on/off state of each channel, a die over-temperature warning, a thermal trip and a supply over-voltage flag) into an 11-bit diagnostic word. A host reads the word serially over three wires: an active-low select, a serial clock and a data line that is only driven while the block is selected.

While the select is inactive, the internal shift register tracks the live status on every system clock. Once the select goes active, the register is frozen and the first bit appears on the data line before the host makes any clock edge. Each falling serial clock edge moves the next bit onto the line, so the host samples on the rising edge. After the eleventh bit the line holds a 1 until the host deselects. Both the serial clock and the select are sampled by a system clock that runs at least eight times faster than the serial clock.

Top module: `diag_serial_readout`

## Requirements
- R1: The word is 11 bits long and leaves the block in this order: the load-fault bits of channels 0, 1, 2 and 3, then the on-state bits of channels 0, 1, 2 and 3, then the temperature warning, the thermal trip and the supply over-voltage.
- R2: The load-fault, temperature warning, thermal trip and over-voltage bits read 0 when their input flag is 1. The on-state bits read 1 for a channel that is commanded on.
- R3: While the synchronized select is inactive (cs_n high), sdo_en is 0 and sdo is high impedance.
- R4: While deselected, the register follows the status inputs continuously. A read returns the status as it stood when the select went low.
- R5: While selected, changes on the status inputs do not alter the bits being shifted out.
- R6: Within SYNC_STAGES+1 system clocks of cs_n falling, and before any serial clock edge, sdo_en is 1 and sdo carries the first bit of the word.
- R7: sdo advances to the next bit only after a falling edge of sclk. It does not change during the high phase of sclk.
- R8: After 11 falling edges, sdo stays 1 regardless of further sclk edges until the select goes inactive. The bit counter never exceeds 11.
- R9: A new selection, including one after an aborted partial read, starts again at the first bit of a freshly captured word.
- R10: During and after a synchronous active-high reset, with cs_n high, sdo_en is 0 and the bit counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| load_fault | input | 4 | Per-channel load fault flags, 1 = fault |
| chan_on | input | 4 | Per-channel commanded state, 1 = on |
| hot_warn | input | 1 | Die temperature warning, 1 = active |
| hot_trip | input | 1 | Thermal trip, 1 = active |
| supply_high | input | 1 | Supply over-voltage, 1 = active |
| sdo | output | 1 | Serial data, high impedance when deselected |
| sdo_en | output | 1 | Drive enable for sdo |

## Verification
The hardest case to reach from the ports is the freeze boundary. The status must change after the select has fallen but before the bits carrying it are shifted out, and the read must still return the earlier value. The bench reaches this by changing every status input in the middle of a read, during the high phase of sclk, and checking the remaining bits against the word from before the change. It also aborts a read after five bits and reselects, which shows that the counter and the register restart from a new capture.

// File: rtl/diag_rd_pkg.sv
package diag_rd_pkg;

    localparam int NCH    = 4;
    localparam int WORD_W = 2 * NCH + 3;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [NCH-1:0] load_fault;
        logic [NCH-1:0] chan_on;
        logic           hot_warn;
        logic           hot_trip;
        logic           supply_high;
    } diag_status_t;

    typedef logic [WORD_W-1:0] diag_word_t;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_SHIFT = 2'd1,
        RD_DONE  = 2'd2
    } rd_state_t;

    // MSB leaves first. Fault flags are inverted (0 = fault active).
    function automatic diag_word_t pack_word(input diag_status_t s);
        diag_word_t w;
        for (int i = 0; i < NCH; i++) begin
            w[WORD_W-1-i]     = ~s.load_fault[i];
            w[WORD_W-1-NCH-i] = s.chan_on[i];
        end
        w[2] = ~s.hot_warn;
        w[1] = ~s.hot_trip;
        w[0] = ~s.supply_high;
        return w;
    endfunction

endpackage

// File: rtl/diag_sync.sv
module diag_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    always_ff @(posedge clk) begin
        if (rst) ff[0] <= RST_VAL;
        else     ff[0] <= d;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) ff[g] <= RST_VAL;
                else     ff[g] <= ff[g-1];
            end
        end
    endgenerate

    assign q = ff[STAGES-1];
endmodule

// File: rtl/diag_word_build.sv
module diag_word_build
    import diag_rd_pkg::*;
(
    input  diag_status_t status,
    output diag_word_t   word
);
    always_comb word = pack_word(status);
endmodule

// File: rtl/diag_shift_core.sv
module diag_shift_core
    import diag_rd_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic          sclk_fall,
    input  logic [W-1:0]  load_word,
    output logic          out_bit,
    output logic [CW-1:0] bit_cnt,
    output logic          done
);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0] shreg;
    rd_state_t    state;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '1;
            bit_cnt <= '0;
            state   <= RD_IDLE;
        end else if (!sel) begin
            shreg   <= load_word;
            bit_cnt <= '0;
            state   <= RD_IDLE;
        end else if (state != RD_DONE && sclk_fall) begin
            shreg   <= {shreg[W-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
            state   <= (bit_cnt == LAST) ? RD_DONE : RD_SHIFT;
        end else if (state == RD_IDLE) begin
            state   <= RD_SHIFT;
        end
    end

    assign done    = (state == RD_DONE);
    assign out_bit = done ? 1'b1 : shreg[W-1];
endmodule

// File: rtl/diag_serial_readout.sv
module diag_serial_readout
    import diag_rd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cs_n,
    input  logic           sclk,
    input  logic [NCH-1:0] load_fault,
    input  logic [NCH-1:0] chan_on,
    input  logic           hot_warn,
    input  logic           hot_trip,
    input  logic           supply_high,
    output logic           sdo,
    output logic           sdo_en
);
    logic             cs_n_s;
    logic             sclk_s;
    logic             sclk_q;
    logic             cs_sel;
    logic             sclk_fall;
    logic             sdo_bit;
    logic             rd_done;
    logic [CNT_W-1:0] bit_cnt;
    diag_status_t     status;
    diag_word_t       word;

    diag_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst(rst), .d(cs_n), .q(cs_n_s)
    );

    diag_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
        .clk(clk), .rst(rst), .d(sclk), .q(sclk_s)
    );

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk_s;
    end

    assign cs_sel    = ~cs_n_s;
    assign sclk_fall = sclk_q & ~sclk_s;

    always_comb begin
        status.load_fault  = load_fault;
        status.chan_on     = chan_on;
        status.hot_warn    = hot_warn;
        status.hot_trip    = hot_trip;
        status.supply_high = supply_high;
    end

    diag_word_build u_build (
        .status(status),
        .word  (word)
    );

    diag_shift_core #(.W(WORD_W), .CW(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .sel      (cs_sel),
        .sclk_fall(sclk_fall),
        .load_word(word),
        .out_bit  (sdo_bit),
        .bit_cnt  (bit_cnt),
        .done     (rd_done)
    );

    assign sdo_en = cs_sel;
    assign sdo    = cs_sel ? sdo_bit : 1'bz;
endmodule

// File: rtl/diag_readout_chk.sv
module diag_readout_chk #(
    parameter int W  = 11,
    parameter int CW = $clog2(W + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          sel,
    input logic          sclk_fall,
    input logic          sdo_bit,
    input logic          sdo_en,
    input logic [CW-1:0] bit_cnt,
    input logic          done
);
    // R3: no drive while deselected
    assert_hiz_deselected_R3: assert property (@(posedge clk) disable iff (rst)
        !sel |-> !sdo_en);

    // R8: idle level after the last bit
    assert_idle_high_R8: assert property (@(posedge clk) disable iff (rst)
        (sel && done) |-> sdo_bit);

    // R8: counter bounded by the word length
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CW'(W));

    // R7: output moves only after a detected falling sclk edge
    assert_stable_between_falls_R7: assert property (@(posedge clk) disable iff (rst)
        (sel && $past(sel) && !$past(sclk_fall)) |-> $stable(sdo_bit));

    // R9: deselection restarts the count
    assert_restart_on_deselect_R9: assert property (@(posedge clk) disable iff (rst)
        !sel |=> (bit_cnt == '0));

    // R10: reset leaves the counter clear
    assert_reset_state_R10: assert property (@(posedge clk)
        rst |=> (bit_cnt == '0 && !done));
endmodule

bind diag_serial_readout diag_readout_chk #(
    .W (diag_rd_pkg::WORD_W),
    .CW(diag_rd_pkg::CNT_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .sel      (cs_sel),
    .sclk_fall(sclk_fall),
    .sdo_bit  (sdo_bit),
    .sdo_en   (sdo_en),
    .bit_cnt  (bit_cnt),
    .done     (rd_done)
);

// File: tb/diag_serial_readout_tb.sv
module diag_serial_readout_tb_top;
    localparam int CLK_P   = 10;
    localparam int HALF    = 8;
    localparam int W       = 11;
    localparam int MAX_CYC = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic [3:0] load_fault = '0;
    logic [3:0] chan_on = '0;
    logic       hot_warn = 1'b0;
    logic       hot_trip = 1'b0;
    logic       supply_high = 1'b0;
    logic       sdo;
    logic       sdo_en;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    diag_serial_readout dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk),
        .load_fault(load_fault), .chan_on(chan_on),
        .hot_warn(hot_warn), .hot_trip(hot_trip), .supply_high(supply_high),
        .sdo(sdo), .sdo_en(sdo_en)
    );

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // v: [3:0] load faults, [7:4] on-state, [8] warn, [9] trip, [10] over-voltage
    task automatic set_status(input logic [10:0] v);
        load_fault  = v[3:0];
        chan_on     = v[7:4];
        hot_warn    = v[8];
        hot_trip    = v[9];
        supply_high = v[10];
    endtask

    // R1/R2: k-th bit out; on-state bits (k=4..7) true, others inverted
    function automatic logic exp_bit(input logic [10:0] v, input int k);
        return (k >= 4 && k <= 7) ? v[k] : ~v[k];
    endfunction

    task automatic read_word(input logic [10:0] v, input bit change_mid,
                             input logic [10:0] v_new);
        cs_n = 1'b0;
        wait_clks(3);
        check("R6 en", sdo_en, 1'b1);
        check("R6 first bit", sdo, exp_bit(v, 0));
        for (int k = 0; k < W; k++) begin
            if (k > 0) check((k < 4 || k > 7) ? "R1/R2 fault bit" : "R1/R2 on bit",
                             sdo, exp_bit(v, k));
            sclk = 1'b1;
            wait_clks(HALF);
            if (change_mid && k == 2) begin
                set_status(v_new);
                wait_clks(1);
                check("R5 frozen", sdo, exp_bit(v, k));
            end
            check("R7 high phase", sdo, exp_bit(v, k));
            sclk = 1'b0;
            wait_clks(HALF);
        end
        check("R8 idle", sdo, 1'b1);
        for (int e = 0; e < 3; e++) begin
            sclk = 1'b1; wait_clks(HALF);
            sclk = 1'b0; wait_clks(HALF);
            check("R8 extra clocks", sdo, 1'b1);
        end
        cs_n = 1'b1;
        wait_clks(4);
        check("R3 deselect", sdo_en, 1'b0);
    endtask

    initial begin
        wait_clks(3);
        check("R10 en in reset", sdo_en, 1'b0);
        rst = 1'b0;
        wait_clks(4);
        check("R10 en after reset", sdo_en, 1'b0);

        // sweep of status patterns (R1, R2, R4, R9)
        for (int i = 0; i < 256; i++) begin
            logic [10:0] v;
            v = {i[0] ^ i[3], i[1] ^ i[6], i[7] ^ i[2], i[7:0]};
            set_status(~v);
            wait_clks(5);
            set_status(v);          // R4: last value before select wins
            wait_clks(4);
            read_word(v, 1'b0, v);
        end

        // R5: change inputs mid-read
        set_status(11'b101_1010_0110);
        wait_clks(4);
        read_word(11'b101_1010_0110, 1'b1, 11'b010_0101_1001);

        // R4: after the read the new status is captured
        wait_clks(4);
        read_word(11'b010_0101_1001, 1'b0, '0);

        // R9: abort after five bits, change status, reselect
        set_status(11'b000_1111_0000);
        wait_clks(4);
        cs_n = 1'b0;
        wait_clks(3);
        for (int k = 0; k < 5; k++) begin
            sclk = 1'b1; wait_clks(HALF);
            sclk = 1'b0; wait_clks(HALF);
        end
        check("R9 mid-read bit", sdo, exp_bit(11'b000_1111_0000, 5));
        cs_n = 1'b1;
        set_status(11'b111_0000_1111);
        wait_clks(4);
        check("R3 aborted deselect", sdo_en, 1'b0);
        read_word(11'b111_0000_1111, 1'b0, '0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule